// File: doc/BRIEF.md
# Control Endpoint Phase Tracker

This block follows the phase of a control transfer on endpoint zero of a USB device. The packet engine reports events to it as single-cycle pulses: a setup packet has arrived (with its direction bit and wLength), an IN packet has gone out, an OUT packet has come in, or a transfer has completed. The function logic can also ask for a stall, or ask that the status stage be held back until it releases it. The block reports the current phase, a stall control, and a one-cycle pulse that tells the packet engine to complete the status handshake.

An IN data stage does not return straight to idle. It first moves to a wait phase, where it stays until the completion interrupt for the final IN packet arrives. A stalled endpoint needs no explicit clear, because the next setup packet releases it. A small six-byte response buffer holds the answers to standard requests that the device handles itself. A status reply uses two of these bytes and a link-timing request uses all six.

Top module: `ep0_ctrl_top`

## Requirements
- R1: After a synchronous reset, phase is 1 (SETUP), stall_out is 0, status_go is 0, status_held is 0 and rsp_rdata is 0.
- R2: A setup packet with wLength 0 leaves phase at 1 (SETUP). Unless the status stage is delayed, status_go is high for exactly one cycle, in the cycle after the setup pulse.
- R3: A setup packet with wLength other than 0 moves phase to 2 (TX) when the direction bit is 1, and to 3 (RX) when it is 0.
- R4: In TX, each IN packet adds its byte count to a running total. When the total reaches wLength, or when the packet is shorter than MAXP bytes, phase moves to 4 (TX_END). A completion pulse seen in TX is ignored. A completion pulse in TX_END returns phase to 1 and issues the status pulse.
- R5: In RX, when the received total reaches wLength, or when an OUT packet is shorter than MAXP bytes, phase returns to 1 and the status pulse is issued.
- R6: A stall request that arrives without a setup packet moves phase to 5 (STALL) and sets stall_out in the next cycle. While in STALL, data and completion pulses are ignored.
- R7: A setup packet received in STALL clears stall_out and is then handled as a fresh setup packet.
- R8: When a setup packet and a stall request arrive in the same cycle, the setup packet wins and the stall request is dropped.
- R9: If delay_req is raised before the status stage or together with it, status_go stays low and status_held goes high. The cycle after delay_release, status_go pulses once and status_held clears.
- R10: The response buffer holds 6 bytes, indices 0 to 5. A read returns the stored byte one cycle after the index is presented. Reads at index 6 or 7 return 0, and writes at those indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_vld | input | 1 | Setup packet received (pulse) |
| setup_dir_in | input | 1 | Direction bit of the setup packet, 1 = device to host |
| setup_len | input | 16 | wLength of the setup packet |
| in_sent | input | 1 | IN packet sent (pulse) |
| in_bytes | input | 16 | Byte count of the IN packet sent |
| out_rcvd | input | 1 | OUT packet received (pulse) |
| out_bytes | input | 16 | Byte count of the OUT packet received |
| xfer_done | input | 1 | Transfer-complete interrupt (pulse) |
| stall_req | input | 1 | Stall request from the function logic |
| delay_req | input | 1 | Function logic asks to hold the status stage |
| delay_release | input | 1 | Releases a held status stage |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_waddr | input | 3 | Response buffer write index |
| rsp_wdata | input | 8 | Response buffer write byte |
| rsp_raddr | input | 3 | Response buffer read index |
| rsp_rdata | output | 8 | Response buffer read byte, registered |
| phase | output | 3 | Current phase: 1 SETUP, 2 TX, 3 RX, 4 TX_END, 5 STALL |
| stall_out | output | 1 | Endpoint stall control |
| status_go | output | 1 | One-cycle pulse to complete the status handshake |
| status_held | output | 1 | Status stage is being held for the function logic |

## Verification
The collision of interest is a fresh setup packet arriving in the same cycle as a stall request. The bench first puts the block in TX and then drives both pulses on one clock edge. The design passes only if the phase returns to SETUP with stall_out low and the zero-length status pulse fires. A second overlap occurs when the status stage falls due in the same cycle as delay_req. There, status_go must stay low while status_held rises.

// File: rtl/ep0_ctrl_pkg.sv
package ep0_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_SETUP = 3'd1,
    PH_TX    = 3'd2,
    PH_RX    = 3'd3,
    PH_TXEND = 3'd4,
    PH_STALL = 3'd5
  } ep0_phase_e;

  localparam int LEN_W     = 16;
  localparam int RSP_BYTES = 6;
endpackage

// File: rtl/ep0_phase_fsm.sv
module ep0_phase_fsm
  import ep0_ctrl_pkg::*;
#(
  parameter int LENW = 16,
  parameter int MAXP = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            setup_vld,
  input  logic            setup_dir_in,
  input  logic [LENW-1:0] setup_len,
  input  logic            in_sent,
  input  logic [LENW-1:0] in_bytes,
  input  logic            out_rcvd,
  input  logic [LENW-1:0] out_bytes,
  input  logic            xfer_done,
  input  logic            stall_req,
  output ep0_phase_e      phase_q,
  output logic            stall_q,
  output logic            status_due,
  output logic            stall_evt
);
  localparam logic [LENW-1:0] MAXP_L = LENW'(MAXP);

  ep0_phase_e      phase_n;
  logic [LENW-1:0] cnt_q, cnt_n;
  logic [LENW-1:0] wlen_q, wlen_n;
  logic [LENW:0]   sum_in, sum_out;
  logic            in_last, out_last;

  assign sum_in   = {1'b0, cnt_q} + {1'b0, in_bytes};
  assign sum_out  = {1'b0, cnt_q} + {1'b0, out_bytes};
  assign in_last  = (sum_in  >= {1'b0, wlen_q}) || (in_bytes  < MAXP_L);
  assign out_last = (sum_out >= {1'b0, wlen_q}) || (out_bytes < MAXP_L);
  assign stall_evt = stall_req && !setup_vld;

  always_comb begin
    phase_n    = phase_q;
    cnt_n      = cnt_q;
    wlen_n     = wlen_q;
    status_due = 1'b0;
    if (setup_vld) begin
      cnt_n  = '0;
      wlen_n = setup_len;
      if (setup_len == '0) begin
        phase_n    = PH_SETUP;
        status_due = 1'b1;
      end else if (setup_dir_in) begin
        phase_n = PH_TX;
      end else begin
        phase_n = PH_RX;
      end
    end else if (stall_req) begin
      phase_n = PH_STALL;
    end else begin
      case (phase_q)
        PH_TX: if (in_sent) begin
          cnt_n = sum_in[LENW-1:0];
          if (in_last) phase_n = PH_TXEND;
        end
        PH_RX: if (out_rcvd) begin
          cnt_n = sum_out[LENW-1:0];
          if (out_last) begin
            phase_n    = PH_SETUP;
            status_due = 1'b1;
          end
        end
        PH_TXEND: if (xfer_done) begin
          phase_n    = PH_SETUP;
          status_due = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SETUP;
      stall_q <= 1'b0;
      cnt_q   <= '0;
      wlen_q  <= '0;
    end else begin
      phase_q <= phase_n;
      stall_q <= (phase_n == PH_STALL);
      cnt_q   <= cnt_n;
      wlen_q  <= wlen_n;
    end
  end
endmodule

// File: rtl/ep0_status_gate.sv
module ep0_status_gate (
  input  logic clk,
  input  logic rst,
  input  logic setup_vld,
  input  logic stall_evt,
  input  logic status_due,
  input  logic delay_req,
  input  logic delay_release,
  output logic status_go,
  output logic status_held
);
  logic flag_q, pend_q;
  logic flag_n, pend_base;

  assign flag_n    = (setup_vld ? 1'b0 : flag_q) | delay_req;
  assign pend_base = setup_vld ? 1'b0 : pend_q;
  assign status_held = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      pend_q    <= 1'b0;
      status_go <= 1'b0;
    end else begin
      status_go <= 1'b0;
      if (stall_evt) begin
        flag_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (status_due) begin
        flag_q <= 1'b0;
        if (flag_n && !delay_release) begin
          pend_q <= 1'b1;
        end else begin
          pend_q    <= 1'b0;
          status_go <= 1'b1;
        end
      end else if (delay_release) begin
        flag_q    <= 1'b0;
        pend_q    <= 1'b0;
        status_go <= pend_base;
      end else begin
        flag_q <= flag_n;
        pend_q <= pend_base;
      end
    end
  end
endmodule

// File: rtl/ep0_rsp_buf.sv
module ep0_rsp_buf #(
  parameter int DEPTH = 6,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int SLOTS = 2 ** IW;
  localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

  logic [DW-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we && (waddr < LIMIT)) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (raddr < LIMIT) rdata <= mem[raddr];
    else                    rdata <= '0;
  end
endmodule

// File: rtl/ep0_ctrl_top.sv
module ep0_ctrl_top
  import ep0_ctrl_pkg::*;
#(
  parameter int LENW  = LEN_W,
  parameter int MAXP  = 64,
  parameter int DEPTH = RSP_BYTES,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            setup_vld,
  input  logic            setup_dir_in,
  input  logic [LENW-1:0] setup_len,
  input  logic            in_sent,
  input  logic [LENW-1:0] in_bytes,
  input  logic            out_rcvd,
  input  logic [LENW-1:0] out_bytes,
  input  logic            xfer_done,
  input  logic            stall_req,
  input  logic            delay_req,
  input  logic            delay_release,
  input  logic            rsp_we,
  input  logic [IW-1:0]   rsp_waddr,
  input  logic [7:0]      rsp_wdata,
  input  logic [IW-1:0]   rsp_raddr,
  output logic [7:0]      rsp_rdata,
  output logic [2:0]      phase,
  output logic            stall_out,
  output logic            status_go,
  output logic            status_held
);
  ep0_phase_e ph;
  logic       due, stall_evt;

  ep0_phase_fsm #(.LENW(LENW), .MAXP(MAXP)) fsm_i (
    .clk(clk), .rst(rst),
    .setup_vld(setup_vld), .setup_dir_in(setup_dir_in), .setup_len(setup_len),
    .in_sent(in_sent), .in_bytes(in_bytes),
    .out_rcvd(out_rcvd), .out_bytes(out_bytes),
    .xfer_done(xfer_done), .stall_req(stall_req),
    .phase_q(ph), .stall_q(stall_out),
    .status_due(due), .stall_evt(stall_evt)
  );

  ep0_status_gate gate_i (
    .clk(clk), .rst(rst),
    .setup_vld(setup_vld), .stall_evt(stall_evt), .status_due(due),
    .delay_req(delay_req), .delay_release(delay_release),
    .status_go(status_go), .status_held(status_held)
  );

  ep0_rsp_buf #(.DEPTH(DEPTH), .DW(8)) buf_i (
    .clk(clk), .rst(rst),
    .we(rsp_we), .waddr(rsp_waddr), .wdata(rsp_wdata),
    .raddr(rsp_raddr), .rdata(rsp_rdata)
  );

  assign phase = ph;
endmodule

// File: rtl/ep0_ctrl_chk.sv
module ep0_ctrl_chk #(
  parameter int LENW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            setup_vld,
  input logic            setup_dir_in,
  input logic [LENW-1:0] setup_len,
  input logic            xfer_done,
  input logic            stall_req,
  input logic            delay_release,
  input logic [2:0]      phase,
  input logic            stall_out,
  input logic            status_go,
  input logic            status_held
);
  // R1
  phase_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (phase >= 3'd1) && (phase <= 3'd5));

  // R6
  stall_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_req && !setup_vld) |=> (phase == 3'd5) && stall_out);

  // R6
  stall_match_chk: assert property (@(posedge clk) disable iff (rst)
    stall_out == (phase == 3'd5));

  // R8
  setup_wins_chk: assert property (@(posedge clk) disable iff (rst)
    setup_vld |=> !stall_out);

  // R3
  setup_in_chk: assert property (@(posedge clk) disable iff (rst)
    (setup_vld && setup_dir_in && (setup_len != '0)) |=> (phase == 3'd2));

  // R2
  setup_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (setup_vld && (setup_len == '0)) |=> (phase == 3'd1));

  // R4
  txend_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase == 3'd4) && xfer_done && !setup_vld && !stall_req) |=> (phase == 3'd1));

  // R9
  held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (status_held && !delay_release && !setup_vld && !stall_req) |=> !status_go);

  // R9
  go_not_held_chk: assert property (@(posedge clk) disable iff (rst)
    status_go |-> !status_held);
endmodule

bind ep0_ctrl_top ep0_ctrl_chk #(.LENW(LENW)) chk_i (
  .clk(clk), .rst(rst), .setup_vld(setup_vld), .setup_dir_in(setup_dir_in),
  .setup_len(setup_len), .xfer_done(xfer_done), .stall_req(stall_req),
  .delay_release(delay_release), .phase(phase), .stall_out(stall_out),
  .status_go(status_go), .status_held(status_held)
);

// File: tb/ep0_ctrl_top_tb_top.sv
module ep0_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        setup_vld, setup_dir_in, in_sent, out_rcvd, xfer_done;
  logic        stall_req, delay_req, delay_release, rsp_we;
  logic [15:0] setup_len, in_bytes, out_bytes;
  logic [2:0]  rsp_waddr, rsp_raddr, phase;
  logic [7:0]  rsp_wdata, rsp_rdata;
  logic        stall_out, status_go, status_held;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0_ctrl_top dut_i (
    .clk(clk), .rst(rst), .setup_vld(setup_vld), .setup_dir_in(setup_dir_in),
    .setup_len(setup_len), .in_sent(in_sent), .in_bytes(in_bytes),
    .out_rcvd(out_rcvd), .out_bytes(out_bytes), .xfer_done(xfer_done),
    .stall_req(stall_req), .delay_req(delay_req), .delay_release(delay_release),
    .rsp_we(rsp_we), .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata),
    .rsp_raddr(rsp_raddr), .rsp_rdata(rsp_rdata), .phase(phase),
    .stall_out(stall_out), .status_go(status_go), .status_held(status_held)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    setup_vld = 0; setup_dir_in = 0; setup_len = 0; in_sent = 0; in_bytes = 0;
    out_rcvd = 0; out_bytes = 0; xfer_done = 0; stall_req = 0; delay_req = 0;
    delay_release = 0; rsp_we = 0; rsp_waddr = 0; rsp_wdata = 0;
  endtask

  task automatic send_setup(input logic dir, input int len);
    setup_vld = 1; setup_dir_in = dir; setup_len = 16'(len);
    cyc();
    idle_inputs();
  endtask

  task automatic send_in(input int n);
    in_sent = 1; in_bytes = 16'(n); cyc(); idle_inputs();
  endtask

  task automatic send_out(input int n);
    out_rcvd = 1; out_bytes = 16'(n); cyc(); idle_inputs();
  endtask

  task automatic send_done();
    xfer_done = 1; cyc(); idle_inputs();
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 1);
    chk("R1 stall", stall_out, 0);
    chk("R1 go", status_go, 0);
    chk("R1 held", status_held, 0);
    chk("R1 rdata", rsp_rdata, 0);
  endtask

  task automatic t_no_data();
    send_setup(1'b1, 0);
    chk("R2 phase", phase, 1);
    chk("R2 go pulse", status_go, 1);
    cyc();
    chk("R2 go single", status_go, 0);
  endtask

  task automatic t_in_stage();
    send_setup(1'b1, 100);
    chk("R3 to TX", phase, 2);
    send_in(64);
    chk("R4 still TX", phase, 2);
    send_done();
    chk("R4 done ignored in TX", phase, 2);
    send_in(36);
    chk("R4 to TX_END", phase, 4);
    chk("R4 no early go", status_go, 0);
    send_done();
    chk("R4 back to SETUP", phase, 1);
    chk("R4 go", status_go, 1);
    send_setup(1'b1, 200);
    send_in(10);
    chk("R4 short to TX_END", phase, 4);
    send_done();
    chk("R4 short back", phase, 1);
  endtask

  task automatic t_out_stage();
    send_setup(1'b0, 128);
    chk("R3 to RX", phase, 3);
    send_out(64);
    chk("R5 still RX", phase, 3);
    send_out(64);
    chk("R5 full back", phase, 1);
    chk("R5 go", status_go, 1);
    send_setup(1'b0, 100);
    send_out(20);
    chk("R5 short back", phase, 1);
    chk("R5 short go", status_go, 1);
  endtask

  task automatic t_stall();
    send_setup(1'b0, 100);
    stall_req = 1; cyc(); idle_inputs();
    chk("R6 phase", phase, 5);
    chk("R6 stall", stall_out, 1);
    send_out(10);
    chk("R6 out ignored", phase, 5);
    send_done();
    chk("R6 done ignored", phase, 5);
    send_setup(1'b0, 0);
    chk("R7 phase", phase, 1);
    chk("R7 stall cleared", stall_out, 0);
    chk("R7 go", status_go, 1);
    stall_req = 1; cyc(); idle_inputs();
    send_setup(1'b1, 8);
    chk("R7 fresh TX", phase, 2);
    chk("R7 stall off", stall_out, 0);
  endtask

  task automatic t_collision();
    send_setup(1'b1, 100);
    setup_vld = 1; setup_dir_in = 0; setup_len = 0; stall_req = 1;
    cyc(); idle_inputs();
    chk("R8 phase", phase, 1);
    chk("R8 stall", stall_out, 0);
    chk("R8 go", status_go, 1);
  endtask

  task automatic t_delay();
    setup_vld = 1; setup_len = 0; delay_req = 1;
    cyc(); idle_inputs();
    chk("R9 no go", status_go, 0);
    chk("R9 held", status_held, 1);
    cyc();
    chk("R9 still held", status_held, 1);
    chk("R9 still no go", status_go, 0);
    delay_release = 1; cyc(); idle_inputs();
    chk("R9 go", status_go, 1);
    chk("R9 held clear", status_held, 0);
    cyc();
    chk("R9 go single", status_go, 0);
  endtask

  task automatic t_buffer();
    for (int i = 0; i < 6; i++) begin
      rsp_we = 1; rsp_waddr = 3'(i); rsp_wdata = 8'(8'hA0 + i); cyc();
    end
    rsp_we = 1; rsp_waddr = 3'd6; rsp_wdata = 8'h55; cyc();
    rsp_waddr = 3'd7; cyc();
    idle_inputs();
    for (int i = 0; i < 6; i++) begin
      rsp_raddr = 3'(i); cyc();
      chk("R10 read", rsp_rdata, 8'hA0 + i);
    end
    rsp_raddr = 3'd6; cyc();
    chk("R10 out of range", rsp_rdata, 0);
    rsp_raddr = 3'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rsp_raddr = 0;
    rst = 1;
    repeat (3) cyc();
    rst = 0;
    t_reset();
    t_no_data();
    t_in_stage();
    t_out_stage();
    t_stall();
    t_collision();
    t_delay();
    t_buffer();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule